// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Processor Arbitration

This block decides when a DRAM controller spends a slot on refresh and which row that refresh targets. A free-running tick divider turns the system clock into refresh deadlines, one every `TICK_CYCLES` clocks (about 15.6 us of wall time in a typical setup). Each deadline adds one owed refresh to a small saturating debt counter. The debt is paid back in slots where the controller reports itself idle. The processor competes for the same slots. It wins a same-cycle contest. The refresh it displaced then takes the very next idle slot.

Refresh rows are visited in ascending order by a row pointer that wraps at `NUM_ROWS - 1`, so any row count works, power of two or not. When the optional skip mode is on, every processor access marks the row it opens, because opening a row recharges it. When the pointer reaches a marked row, the owed refresh is retired without using a slot. The marks cover one refresh period and are wiped when the pointer wraps back to row 0. Pin-level strobe timing is left to the controller. This block only issues grants.

Top module: `rfs_scheduler`

## Requirements
- R1: With the controller idle and no processor traffic, `ref_gnt` pulses every `TICK_CYCLES` clocks. The first pulse comes in the cycle that follows clock edge number `TICK_CYCLES` after reset is released.
- R2: A grant (`cpu_gnt` or `ref_gnt`) is given only in a cycle where `ctrl_idle` is high. The two grants are never high together. `cpu_gnt` is given to a request whenever no refresh is owed.
- R3: If `cpu_req` is high while an unmarked refresh is owed in an idle cycle, and no refresh was displaced before, the processor gets `cpu_gnt` and `ref_gnt` stays low.
- R4: A refresh displaced by a processor grant is granted in the next idle cycle, even if `cpu_req` is high then. The priority flag is then cleared, so the processor wins the following tie again.
- R5: `ref_row` starts at 0 and steps by one after each retired refresh, wrapping from `NUM_ROWS - 1` to 0. Without a retirement it holds its value.
- R6: With `skip_en` high, each `cpu_gnt` marks the row on `cpu_row`. When the pointer row is marked and a refresh is owed, that refresh is retired with no `ref_gnt` pulse, and the pointer moves on.
- R7: Marks cover only the current period. They are cleared when the row pointer wraps to 0, and by reset.
- R8: With `skip_en` low, every row is granted an explicit refresh in each period, whatever processor traffic there was.
- R9: The owed count saturates at `PEND_LIMIT`. A deadline that arrives while the counter is full and nothing is retired sets `overflow`. Only reset clears it.
- R10: After reset, `ref_gnt`, `cpu_gnt` (with no request), and `overflow` are low, and `ref_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor wants a memory slot |
| cpu_row | input | ROW_W | Row the processor access opens |
| ctrl_idle | input | 1 | Controller can start a new access this cycle |
| skip_en | input | 1 | Enable skipping of rows already opened this period |
| cpu_gnt | output | 1 | Processor access granted this cycle |
| ref_gnt | output | 1 | Refresh granted this cycle |
| ref_row | output | ROW_W | Row targeted by the current or next refresh |
| overflow | output | 1 | Sticky: a deadline was lost with the debt counter full |

## Verification
An owed refresh and a processor request can meet in the same idle cycle. The bench provokes this by holding `ctrl_idle` low with `cpu_req` asserted until two deadlines have accumulated, then opening single idle slots. It checks that the processor takes the first slot, that the displaced refresh takes the next one despite the still-pending request, and that priority then returns to the processor. A second overlap, between a processor mark and a refresh of the same row, is swept over every mark pattern of a six-row configuration. The expected refresh row list of two periods is built arithmetically from the mark mask.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Width needed to index n rows (at least one bit).
    function automatic int unsigned row_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width of a counter that must hold the value n.
    function automatic int unsigned count_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Per-cycle arbitration outcome.
    typedef struct packed {
        logic cpu;   // processor slot granted
        logic refr;  // explicit refresh slot granted
        logic skip;  // owed refresh retired without a slot (row already opened)
    } arb_t;

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int unsigned TICK_CYCLES = 1950
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = (TICK_CYCLES <= 2) ? 1 : $clog2(TICK_CYCLES);
    localparam logic [TW-1:0] TOP = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == TOP);
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr
    import rfs_pkg::*;
#(
    parameter int unsigned PEND_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic retire,
    output logic owed,
    output logic overflow
);
    localparam int unsigned CW = count_bits(PEND_LIMIT);
    localparam logic [CW-1:0] FULL = CW'(PEND_LIMIT);

    logic [CW-1:0] debt;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt  <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case ({tick, retire})
                2'b10: begin
                    if (debt == FULL) begin
                        ovf_q <= 1'b1;
                    end else begin
                        debt <= debt + 1'b1;
                    end
                end
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign owed     = (debt != '0);
    assign overflow = ovf_q;
endmodule

// File: rtl/rfs_row_walker.sv
module rfs_row_walker
    import rfs_pkg::*;
#(
    parameter int unsigned NUM_ROWS  = 256,
    parameter bit          ROW_TRACK = 1'b1,
    localparam int unsigned ROW_W    = row_bits(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             skip_en,
    input  logic             mark_vld,
    input  logic [ROW_W-1:0] mark_row,
    input  logic             advance,
    output logic [ROW_W-1:0] row,
    output logic             row_marked
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] ptr;
    logic             wrap;

    assign wrap = advance && (ptr == LAST_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= wrap ? '0 : ptr + 1'b1;
        end
    end

    assign row = ptr;

    generate
        if (ROW_TRACK) begin : g_track
            logic [NUM_ROWS-1:0] opened;

            always_ff @(posedge clk) begin
                if (rst) begin
                    opened <= '0;
                end else begin
                    for (int i = 0; i < NUM_ROWS; i++) begin
                        if (mark_vld && (mark_row == ROW_W'(i))) begin
                            opened[i] <= 1'b1;
                        end else if (wrap) begin
                            opened[i] <= 1'b0;
                        end
                    end
                end
            end

            assign row_marked = skip_en && opened[ptr];
        end else begin : g_plain
            logic unused_track;
            assign unused_track = ^{skip_en, mark_vld, mark_row};
            assign row_marked   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rfs_arbiter.sv
module rfs_arbiter
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic ctrl_idle,
    input  logic owed,
    input  logic row_marked,
    output arb_t arb
);
    logic ref_first;
    logic need_ref;

    assign need_ref = owed && !row_marked;

    always_comb begin
        arb      = '0;
        arb.skip = owed && row_marked;
        if (ctrl_idle) begin
            if (need_ref && (ref_first || !cpu_req)) begin
                arb.refr = 1'b1;
            end else if (cpu_req) begin
                arb.cpu = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_first <= 1'b0;
        end else if (arb.refr || arb.skip || !owed) begin
            ref_first <= 1'b0;
        end else if (arb.cpu && need_ref) begin
            ref_first <= 1'b1;
        end
    end
endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler
    import rfs_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1950,
    parameter int unsigned NUM_ROWS    = 256,
    parameter int unsigned PEND_LIMIT  = 4,
    parameter bit          ROW_TRACK   = 1'b1,
    localparam int unsigned ROW_W      = row_bits(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req,
    input  logic [ROW_W-1:0] cpu_row,
    input  logic             ctrl_idle,
    input  logic             skip_en,
    output logic             cpu_gnt,
    output logic             ref_gnt,
    output logic [ROW_W-1:0] ref_row,
    output logic             overflow
);
    logic tick;
    logic refresh_owed;
    logic row_marked;
    arb_t arb;

    rfs_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rfs_debt_ctr #(.PEND_LIMIT(PEND_LIMIT)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .retire   (arb.refr || arb.skip),
        .owed     (refresh_owed),
        .overflow (overflow)
    );

    rfs_row_walker #(.NUM_ROWS(NUM_ROWS), .ROW_TRACK(ROW_TRACK)) u_rows (
        .clk        (clk),
        .rst        (rst),
        .skip_en    (skip_en),
        .mark_vld   (arb.cpu),
        .mark_row   (cpu_row),
        .advance    (arb.refr || arb.skip),
        .row        (ref_row),
        .row_marked (row_marked)
    );

    rfs_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .ctrl_idle  (ctrl_idle),
        .owed       (refresh_owed),
        .row_marked (row_marked),
        .arb        (arb)
    );

    assign cpu_gnt = arb.cpu;
    assign ref_gnt = arb.refr;
endmodule

// File: rtl/rfs_scheduler_chk.sv
module rfs_scheduler_chk #(
    parameter int unsigned NUM_ROWS = 256,
    parameter int unsigned ROW_W    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             ctrl_idle,
    input logic             skip_en,
    input logic             refresh_owed,
    input logic             cpu_gnt,
    input logic             ref_gnt,
    input logic [ROW_W-1:0] ref_row,
    input logic             overflow
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] row_after;
    always_comb row_after = (ref_row == LAST_ROW) ? '0 : ref_row + 1'b1;

    a_r2_idle_only: assert property (@(posedge clk) disable iff (rst)
        !ctrl_idle |-> !(cpu_gnt || ref_gnt));

    a_r2_one_grant: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && ref_gnt));

    a_r2_cpu_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> cpu_req);

    a_r1_ref_needs_debt: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> refresh_owed);

    a_r3_tie_served: assert property (@(posedge clk) disable iff (rst)
        (ctrl_idle && cpu_req && refresh_owed && !skip_en) |-> (cpu_gnt || ref_gnt));

    a_r5_row_range: assert property (@(posedge clk) disable iff (rst)
        ref_row <= LAST_ROW);

    a_r5_row_hold: assert property (@(posedge clk) disable iff (rst)
        (!skip_en && !ref_gnt) |=> $stable(ref_row));

    a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |=> (ref_row == $past(row_after)));

    a_r9_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind rfs_scheduler rfs_scheduler_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .ctrl_idle    (ctrl_idle),
    .skip_en      (skip_en),
    .refresh_owed (refresh_owed),
    .cpu_gnt      (cpu_gnt),
    .ref_gnt      (ref_gnt),
    .ref_row      (ref_row),
    .overflow     (overflow)
);

// File: tb/rfs_scheduler_test.sv
`timescale 1ns/1ps
module rfs_scheduler_test;
    localparam int TICK = 8;
    localparam int ROWS = 6;
    localparam int LIM  = 4;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [RW-1:0] cpu_row = '0;
    logic          ctrl_idle = 1'b0;
    logic          skip_en = 1'b0;
    logic          cpu_gnt, ref_gnt, overflow;
    logic [RW-1:0] ref_row;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rfs_scheduler #(
        .TICK_CYCLES(TICK), .NUM_ROWS(ROWS), .PEND_LIMIT(LIM), .ROW_TRACK(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_row(cpu_row),
        .ctrl_idle(ctrl_idle), .skip_en(skip_en), .cpu_gnt(cpu_gnt),
        .ref_gnt(ref_gnt), .ref_row(ref_row), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Returns at the negedge (+1) of the first cycle after reset edge E0.
    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // Two refresh periods with optional marks driven in cycles 1..ROWS.
    task automatic sweep_body(input bit skip, input int mask);
        int got[16];
        int expv[16];
        int ng = 0;
        int ne = 0;
        for (int r = 0; r < ROWS; r++)
            if (!(skip && ((mask >> r) & 1) == 1)) begin expv[ne] = r; ne++; end
        for (int r = 0; r < ROWS; r++) begin expv[ne] = r; ne++; end
        for (int n = 1; n <= 12 * TICK + 3; n++) begin
            if (n <= ROWS) begin
                cpu_req = ((mask >> (n - 1)) & 1) == 1;
                cpu_row = RW'(n - 1);
            end else begin
                cpu_req = 1'b0;
            end
            #1;
            if (cpu_req) chk(cpu_gnt == 1'b1, "R2 cpu granted with no debt", int'(cpu_gnt), 1);
            if (ref_gnt) begin
                if (ng < 16) got[ng] = int'(ref_row);
                ng++;
            end
            @(negedge clk);
        end
        cpu_req = 1'b0;
        chk(ng == ne, skip ? "R6 explicit refresh count" : "R8 explicit refresh count", ng, ne);
        for (int i = 0; i < ne; i++) begin
            if (i < ng) begin
                if (i >= ne - ROWS)
                    chk(got[i] == expv[i], "R7 second period full walk", got[i], expv[i]);
                else if (skip)
                    chk(got[i] == expv[i], "R6 marked rows skipped", got[i], expv[i]);
                else
                    chk(got[i] == expv[i], "R8 all rows refreshed", got[i], expv[i]);
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int hits[8];
        int nh;

        // R10 reset state
        ctrl_idle = 1'b1; skip_en = 1'b0; cpu_req = 1'b0;
        do_reset();
        chk(ref_gnt == 1'b0, "R10 ref_gnt after reset", int'(ref_gnt), 0);
        chk(cpu_gnt == 1'b0, "R10 cpu_gnt after reset", int'(cpu_gnt), 0);
        chk(overflow == 1'b0, "R10 overflow after reset", int'(overflow), 0);
        chk(ref_row == '0, "R10 ref_row after reset", int'(ref_row), 0);

        // R1 deadline spacing, R5 row order
        do_reset();
        nh = 0;
        for (int n = 1; n <= 5 * TICK + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            if (ref_gnt) begin
                if (nh < 8) hits[nh] = n;
                chk(int'(ref_row) == nh % ROWS, "R5 row sequence", int'(ref_row), nh % ROWS);
                nh++;
            end
        end
        chk(nh == 5, "R1 refresh count", nh, 5);
        for (int k = 0; k < 5; k++)
            if (k < nh) chk(hits[k] == (k + 1) * TICK, "R1 refresh timing", hits[k], (k + 1) * TICK);

        // R3 / R4 tie between owed refresh and processor
        ctrl_idle = 1'b0; cpu_req = 1'b1; cpu_row = 3'd2; skip_en = 1'b0;
        do_reset();
        for (int n = 1; n <= 17; n++) begin
            chk(!cpu_gnt && !ref_gnt, "R2 no grant while busy", int'({cpu_gnt, ref_gnt}), 0);
            @(negedge clk);
            #1;
        end
        ctrl_idle = 1'b1; #1;
        chk(cpu_gnt == 1'b1, "R3 processor wins tie", int'(cpu_gnt), 1);
        chk(ref_gnt == 1'b0, "R3 refresh waits on tie", int'(ref_gnt), 0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            ctrl_idle = 1'b0; #1;
            chk(!cpu_gnt && !ref_gnt, "R2 no preemption during access", int'({cpu_gnt, ref_gnt}), 0);
        end
        @(negedge clk);
        ctrl_idle = 1'b1; #1;
        chk(ref_gnt == 1'b1, "R4 displaced refresh next", int'(ref_gnt), 1);
        chk(cpu_gnt == 1'b0, "R4 processor held back", int'(cpu_gnt), 0);
        chk(ref_row == 3'd0, "R4 displaced refresh row", int'(ref_row), 0);
        @(negedge clk); #1;
        chk(cpu_gnt == 1'b1, "R4 priority returns to processor", int'(cpu_gnt), 1);
        @(negedge clk); #1;
        chk(ref_gnt == 1'b1, "R4 second displaced refresh", int'(ref_gnt), 1);
        chk(ref_row == 3'd1, "R5 row after one refresh", int'(ref_row), 1);
        @(negedge clk);
        cpu_req = 1'b0; #1;
        chk(ref_gnt == 1'b1, "R4 remaining debt served", int'(ref_gnt), 1);
        chk(ref_row == 3'd2, "R5 row step", int'(ref_row), 2);

        // R9 overflow
        ctrl_idle = 1'b0; cpu_req = 1'b0;
        do_reset();
        for (int n = 1; n <= 34; n++) begin @(negedge clk); #1; end
        chk(overflow == 1'b0, "R9 no overflow at limit", int'(overflow), 0);
        for (int n = 35; n <= 41; n++) begin @(negedge clk); #1; end
        chk(overflow == 1'b1, "R9 overflow on lost deadline", int'(overflow), 1);
        ctrl_idle = 1'b1; #1;
        for (int k = 0; k < LIM; k++) begin
            chk(ref_gnt == 1'b1, "R9 saturated debt drains", int'(ref_gnt), 1);
            chk(int'(ref_row) == k, "R5 drain row", int'(ref_row), k);
            @(negedge clk); #1;
        end
        chk(ref_gnt == 1'b0, "R9 debt held at limit", int'(ref_gnt), 0);
        chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
        do_reset();
        chk(overflow == 1'b0, "R10 reset clears overflow", int'(overflow), 0);

        // R7 reset clears marks
        skip_en = 1'b1; ctrl_idle = 1'b1;
        do_reset();
        for (int r = 0; r < ROWS; r++) begin
            cpu_req = 1'b1; cpu_row = RW'(r);
            @(negedge clk);
        end
        cpu_req = 1'b0;
        do_reset();
        sweep_body(1'b1, 0);

        // R6 / R8 sweep over every mark pattern in both modes
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < (1 << ROWS); m++) begin
                skip_en = (s == 1);
                ctrl_idle = 1'b1;
                do_reset();
                sweep_body(s == 1, m);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule